// File: doc/BRIEF.md
# Circular Self-Test Register with Embedded Adder Under Test

This block is a single register that both generates test stimulus for a small adder and compacts the adder's responses into a signature, all in one closed loop. On every active edge of a test run, the register's current contents drive the adder inputs. The next register value is the current contents rotated up by one bit, plus an optional feedback term taken from the top bit, with the adder's response XORed in. The response therefore becomes the next pattern, and no separate pattern generator is needed.

Before a run, software supplies a seed, a feedback tap mask and a step count, and then pulses start. When the count is used up, done rises and the register contents are held as the signature. With self-test mode off, the register is an ordinary parallel-load register that feeds the adder with functional data. The adder response is visible at a port at all times.

Top module: `circ_selftest_reg`

## Requirements
- R1: While rst_n is low, signature is 0 and busy and done are 0.
- R2: A start pulse with test_mode=1 loads seed into the register on that edge. If cycles is nonzero, busy is 1 on the following cycle.
- R3: Each run step computes next[i] = cur[i-1] ^ (taps[i] & cur[W-1]) ^ resp[i] for i>=1, and next[0] = cur[W-1] ^ resp[0]. Bit 0 of taps has no effect.
- R4: The adder takes a = register bits [W/2-1:0] and b = bits [W-1:W/2]. resp holds the (W/2+1)-bit sum a+b in its low bits and zeros above, and it follows the register combinationally.
- R5: A run performs exactly cycles steps. done rises cycles edges after the load edge, and with cycles=0 done rises on the load edge itself.
- R6: After done rises, signature and done stay unchanged until the next start or until test_mode goes low.
- R7: With test_mode=0, the register loads norm_data on every edge, start has no effect, and busy and done are 0.
- R8: A start during a run discards that run and begins a new one from the new seed and count.
- R9: busy and done are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_mode | input | 1 | 1 selects self-test, 0 selects functional parallel load |
| start | input | 1 | Single-cycle pulse that begins a run |
| seed | input | W | Initial register value for a run |
| taps | input | W | Feedback mask from the top bit; bit 0 unused |
| cycles | input | CW | Number of run steps |
| norm_data | input | W | Functional data loaded when test_mode is 0 |
| signature | output | W | Register contents; the signature once done is 1 |
| resp | output | W | Adder response to the current register contents |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The run has finished and the signature is held |

## Verification
The assertions assume that seed, taps and cycles are stable on the edge where start is sampled. They also assume that start and test_mode change only between edges, so that a load, a step or a hold is decided by one clean sample. The bench changes every input on the falling clock edge and holds seed and count steady through the start pulse. It interrupts a run only by a fresh start or by leaving test mode, which are the two exits the hold property allows for.

// File: rtl/circ_st_pkg.sv
`timescale 1ns/1ps
package circ_st_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_e;
endpackage

// File: rtl/circ_st_adder.sv
`timescale 1ns/1ps
module circ_st_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] state_i,
  output logic [W-1:0] resp_o
);
  localparam int H = W / 2;

  function automatic logic [W-1:0] add_resp(input logic [W-1:0] cur);
    logic [H:0] sum;
    sum = {1'b0, cur[H-1:0]} + {1'b0, cur[2*H-1:H]};
    return W'(sum);
  endfunction

  assign resp_o = add_resp(state_i);
endmodule

// File: rtl/circ_st_ctrl.sv
`timescale 1ns/1ps
module circ_st_ctrl
  import circ_st_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_mode,
  input  logic          start,
  input  logic [CW-1:0] cycles,
  output logic          load_seed,
  output logic          step_en,
  output logic          par_load,
  output logic          busy,
  output logic          done
);
  run_state_e    st;
  logic [CW-1:0] cnt;
  logic          last_step;

  assign load_seed = test_mode & start;
  assign par_load  = ~test_mode;
  assign step_en   = test_mode & ~start & (st == ST_RUN);
  assign last_step = (cnt == CW'(1));
  assign busy      = (st == ST_RUN);
  assign done      = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (!test_mode) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (start) begin
      cnt <= cycles;
      st  <= (cycles == '0) ? ST_DONE : ST_RUN;
    end else if (st == ST_RUN) begin
      cnt <= cnt - CW'(1);
      if (last_step) st <= ST_DONE;
    end
  end

  assert_run_cnt_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |-> (cnt != '0));
  assert_zero_count_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && start && cycles == '0) |=> done);
  assert_start_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && start && cycles != '0) |=> (busy && cnt == $past(cycles)));
  assert_step_counts_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !last_step) |=> (busy && cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/circ_st_core.sv
`timescale 1ns/1ps
module circ_st_core #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         par_load,
  input  logic         load_seed,
  input  logic         step_en,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] taps,
  input  logic [W-1:0] norm_data,
  input  logic [W-1:0] resp,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] TAP_USE = {{(W-1){1'b1}}, 1'b0};

  function automatic logic [W-1:0] next_state(
    input logic [W-1:0] cur,
    input logic [W-1:0] tap,
    input logic [W-1:0] rsp
  );
    logic [W-1:0] rot;
    logic [W-1:0] fb;
    rot = {cur[W-2:0], cur[W-1]};
    fb  = (tap & TAP_USE) & {W{cur[W-1]}};
    return rot ^ fb ^ rsp;
  endfunction

  logic [W-1:0] state_q;
  assign state_o = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state_q <= '0;
    else if (par_load)   state_q <= norm_data;
    else if (load_seed)  state_q <= seed;
    else if (step_en)    state_q <= next_state(state_q, taps, resp);
  end

  assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_load && load_seed) |=> (state_q == $past(seed)));
  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_load && !load_seed && !step_en) |=> $stable(state_q));
  assert_parallel_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    par_load |=> (state_q == $past(norm_data)));
endmodule

// File: rtl/circ_selftest_reg.sv
`timescale 1ns/1ps
module circ_selftest_reg #(
  parameter int W  = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_mode,
  input  logic          start,
  input  logic [W-1:0]  seed,
  input  logic [W-1:0]  taps,
  input  logic [CW-1:0] cycles,
  input  logic [W-1:0]  norm_data,
  output logic [W-1:0]  signature,
  output logic [W-1:0]  resp,
  output logic          busy,
  output logic          done
);
  logic load_seed;
  logic step_en;
  logic par_load;
  logic [W-1:0] state_w;

  circ_st_ctrl #(.CW(CW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
    .cycles(cycles), .load_seed(load_seed), .step_en(step_en),
    .par_load(par_load), .busy(busy), .done(done)
  );

  circ_st_core #(.W(W)) core_i (
    .clk(clk), .rst_n(rst_n), .par_load(par_load), .load_seed(load_seed),
    .step_en(step_en), .seed(seed), .taps(taps), .norm_data(norm_data),
    .resp(resp), .state_o(state_w)
  );

  circ_st_adder #(.W(W)) uut_i (
    .state_i(state_w), .resp_o(resp)
  );

  assign signature = state_w;

  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_normal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> (!busy && !done));
endmodule

// File: tb/circ_selftest_reg_tb_top.sv
`timescale 1ns/1ps
module circ_selftest_reg_tb_top;
  localparam int W = 4;
  localparam int CW = 8;
  localparam int NV = 8;
  // {seed, taps, cycles, expected signature}
  localparam logic [19:0] VEC [NV] = '{
    {4'h1, 4'h2, 8'd1, 4'h3},
    {4'h1, 4'h2, 8'd2, 4'h5},
    {4'h1, 4'h2, 8'd3, 4'h8},
    {4'h1, 4'h2, 8'd4, 4'h1},
    {4'hF, 4'h0, 8'd1, 4'h9},
    {4'hF, 4'h2, 8'd1, 4'hB},
    {4'hF, 4'h3, 8'd1, 4'hB},
    {4'h0, 4'h2, 8'd5, 4'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] seed = '0;
  logic [W-1:0] taps = '0;
  logic [CW-1:0] cycles = '0;
  logic [W-1:0] norm_data = '0;
  logic [W-1:0] signature;
  logic [W-1:0] resp;
  logic busy;
  logic done;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  circ_selftest_reg #(.W(W), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
    .seed(seed), .taps(taps), .cycles(cycles), .norm_data(norm_data),
    .signature(signature), .resp(resp), .busy(busy), .done(done)
  );

  function automatic logic [3:0] model_sig(input logic [3:0] s, input logic [3:0] t,
                                           input int n);
    logic [3:0] r;
    logic [2:0] sum;
    logic [3:0] nx;
    r = s;
    for (int k = 0; k < n; k++) begin
      sum = {1'b0, r[1:0]} + {1'b0, r[3:2]};
      nx[0] = r[3] ^ sum[0];
      nx[1] = r[0] ^ (t[1] & r[3]) ^ sum[1];
      nx[2] = r[1] ^ (t[2] & r[3]) ^ sum[2];
      nx[3] = r[2] ^ (t[3] & r[3]);
      r = nx;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] s, input logic [3:0] t, input int n,
                     input logic [3:0] exp);
    int k;
    @(negedge clk);
    test_mode = 1'b1; seed = s; taps = t; cycles = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n > 0) begin
      check(busy == 1'b1, "R2 busy after start", busy, 1);
      check(signature == s, "R2 seed loaded", signature, s);
    end
    k = 0;
    while (!done && k < 300) begin
      @(negedge clk);
      k++;
    end
    check(k == n, "R5 step count", k, n);
    check(signature == exp, "R3 signature", signature, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(signature == 4'h0 && !busy && !done, "R1 reset state",
          {busy, done, signature}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run(VEC[i][19:16], VEC[i][15:12], int'(VEC[i][11:4]), VEC[i][3:0]);

    // R3: longer runs against bench model, default polynomial and others
    run(4'h9, 4'h2, 10, model_sig(4'h9, 4'h2, 10));
    run(4'h6, 4'hC, 37, model_sig(4'h6, 4'hC, 37));
    run(4'h1, 4'h2, 0, 4'h1); // R5 zero count

    // R6: hold after done
    run(4'h3, 4'h2, 6, model_sig(4'h3, 4'h2, 6));
    repeat (4) @(negedge clk);
    check(signature == model_sig(4'h3, 4'h2, 6) && done && !busy, "R6 hold",
          signature, model_sig(4'h3, 4'h2, 6));
    check(!(busy && done), "R9 exclusive", {busy, done}, 2);

    // R8: restart mid-run
    @(negedge clk);
    seed = 4'h5; taps = 4'h2; cycles = 8'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy && !done, "R8 mid-run", {busy, done}, 2);
    run(4'h1, 4'h2, 2, 4'h5);

    // R7 and R4: normal mode parallel load, start ignored, adder response
    @(negedge clk);
    test_mode = 1'b0; norm_data = 4'hB; start = 1'b1;
    @(negedge clk);
    check(signature == 4'hB, "R7 parallel load", signature, 4'hB);
    check(!busy && !done, "R7 start ignored", {busy, done}, 0);
    check(resp == 4'h5, "R4 resp 11+10", resp, 4'h5);
    norm_data = 4'hF;
    @(negedge clk);
    start = 1'b0;
    check(resp == 4'h6, "R4 resp 11+11", resp, 4'h6);
    norm_data = 4'h0;
    @(negedge clk);
    check(resp == 4'h0 && signature == 4'h0, "R4 resp zero", resp, 0);

    // R1: reset in the middle of a run
    @(negedge clk);
    test_mode = 1'b1; seed = 4'h7; cycles = 8'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(signature == 4'h0 && !busy && !done, "R1 async reset",
          {busy, done, signature}, 0);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule